// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked host and a 128K x 8 asynchronous static RAM. The host posts one single-word request at a time: a 17-bit word address, a direction bit and, for a write, one byte. The controller then produces the memory's select, read-enable and write-enable strobes and drives the address and the data bus. Each strobe is held for a whole number of clock cycles, and that number is worked out at elaboration time from the memory's nanosecond minimums and a clock-period parameter.

The memory is selected only when the low-true select is low and the high-true select is high. A read holds write enable high and pulls the read enable low. A write pulls write enable low while the chip is selected. The data bus is split into an outgoing byte, an incoming byte and a driver enable. The controller switches its driver on only inside the write phase, and only after the memory has had time to release a bus it was driving for a read that just ended.

The host side is a request/ready handshake. A request is taken only in a cycle where ready is high. Completion is signalled by a one-cycle done pulse, and read data is valid in that same cycle.

Top module: `sram_async_ctl`

## Requirements
- R1: During and right after reset, ready is 1, done is 0, the memory is deselected (mem_sel_n=1, mem_sel=0), mem_rd_n=1, mem_wr_n=1 and mem_drive=0.
- R2: A read request (req_we=0) selects the memory with mem_wr_n=1 and holds mem_rd_n low for RD_CYC consecutive cycles with a stable address. RD_CYC is the largest of ceil(12/CLK_NS), ceil(6/CLK_NS) and ceil(12/CLK_NS), with a floor of one, which is 3 at CLK_NS=5.
- R3: Read data is sampled from mem_din on the last read-enable cycle. In the next cycle done is 1 for exactly one cycle and rdata holds the sampled byte. Ready is 1 in the cycle after done. Exactly 4 cycles pass from the accepting edge to done, for reads and for writes alike, at the default parameters.
- R4: A write request (req_we=1) holds mem_wr_n low for WR_CYC cycles while the memory is selected, then holds one further cycle with mem_wr_n high and the address and data unchanged. WR_CYC is the largest of ceil(10/CLK_NS), ceil(7/CLK_NS), ceil(10/CLK_NS) and ceil(12/CLK_NS)-1, with a floor of one, which is 2 at CLK_NS=5. The byte on mem_dout is the byte stored.
- R5: mem_drive is 1 only in the write and hold cycles of a write, and it is never 1 while mem_rd_n is 0.
- R6: mem_drive does not rise until mem_rd_n has been high for at least TURN_CYC = ceil(7/CLK_NS) cycles (2 at default), so the controller never drives while the memory is still releasing the bus.
- R7: A request raised while ready is 0 is ignored: it starts no access and produces no done pulse.
- R8: Whenever ready is 1, the memory is deselected and mem_drive is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Host request, taken when ready is 1 |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write byte |
| ready | output | 1 | Controller idle, can take a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read byte, valid with done |
| mem_a | output | 17 | Memory address |
| mem_sel_n | output | 1 | Low-true chip select |
| mem_sel | output | 1 | High-true chip select |
| mem_rd_n | output | 1 | Low-true output (read) enable |
| mem_wr_n | output | 1 | Low-true write enable |
| mem_dout | output | 8 | Byte driven to the memory data bus |
| mem_din | input | 8 | Byte read from the memory data bus |
| mem_drive | output | 1 | Controller drives the data bus |

## Verification
Writes go to the lowest and highest addresses and to alternating-bit addresses, using all-ones, all-zeros and checkerboard bytes. A stuck or swapped address or data bit therefore reads back wrong. A read issued straight after a write, and a write issued straight after a read, show whether the bus handover leaves a cycle in which both sides drive: the memory model keeps driving for the release time after its read enable rises. An overwrite followed by a read separates a real write from a stale value. A request raised while the controller is busy, aimed at an address that already holds known data, shows whether busy-time requests leak into the memory.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_TURN  = 3'd1,
        PH_READ  = 3'd2,
        PH_WRITE = 3'd3,
        PH_HOLD  = 3'd4,
        PH_DONE  = 3'd5
    } phase_e;

    // cycles needed to cover a minimum of ns nanoseconds, never fewer than one
    function automatic int cyc_of(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_gap.sv
// Counts the cycles since the last read released the read enable.
module sram_ctl_gap #(
    parameter int TURN_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic clear_next
);
    localparam int TW = $clog2(TURN_CYC + 1) + 1;

    logic [TW-1:0] gap_d, gap_q;

    always_comb begin
        gap_d = gap_q;
        if (load)
            gap_d = TW'(TURN_CYC);
        else if (gap_q != '0)
            gap_d = gap_q - 1'b1;
        // true when the bus is free to drive in the coming cycle
        clear_next = !load && (gap_q <= TW'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            gap_q <= '0;
        else
            gap_q <= gap_d;
    end

endmodule

// File: rtl/sram_ctl_seq.sv
// Access sequencer: all memory pins come straight from registers.
module sram_ctl_seq #(
    parameter int AW     = 17,
    parameter int DW     = 8,
    parameter int RD_CYC = 3,
    parameter int WR_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          gap_clear,
    output logic          rd_end,
    output logic          ready,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] mem_a,
    output logic          mem_sel_n,
    output logic          mem_sel,
    output logic          mem_rd_n,
    output logic          mem_wr_n,
    output logic [DW-1:0] mem_dout,
    input  logic [DW-1:0] mem_din,
    output logic          mem_drive
);
    import sram_ctl_pkg::*;

    localparam int CW = $clog2(max2(RD_CYC, WR_CYC) + 1);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
        logic [AW-1:0] a;
        logic [DW-1:0] wd;
        logic [DW-1:0] rd;
        logic          sel_n;
        logic          sel;
        logic          rd_n;
        logic          wr_n;
        logic          drv;
        logic          dn;
    } st_t;

    localparam st_t ST_RST = '{
        ph: PH_IDLE, cnt: '0, a: '0, wd: '0, rd: '0,
        sel_n: 1'b1, sel: 1'b0, rd_n: 1'b1, wr_n: 1'b1, drv: 1'b0, dn: 1'b0
    };

    st_t  st_d, st_q;
    logic launch_wr;

    always_comb begin
        st_d      = st_q;
        st_d.dn   = 1'b0;
        rd_end    = 1'b0;
        launch_wr = 1'b0;
        case (st_q.ph)
            PH_IDLE: begin
                if (req) begin
                    st_d.a  = req_addr;
                    st_d.wd = req_wdata;
                    if (req_we) begin
                        if (gap_clear) launch_wr = 1'b1;
                        else           st_d.ph   = PH_TURN;
                    end else begin
                        st_d.ph    = PH_READ;
                        st_d.cnt   = CW'(RD_CYC - 1);
                        st_d.sel_n = 1'b0;
                        st_d.sel   = 1'b1;
                        st_d.rd_n  = 1'b0;
                    end
                end
            end
            PH_TURN: begin
                if (gap_clear) launch_wr = 1'b1;
            end
            PH_READ: begin
                if (st_q.cnt == '0) begin
                    st_d.rd    = mem_din;
                    st_d.ph    = PH_DONE;
                    st_d.sel_n = 1'b1;
                    st_d.sel   = 1'b0;
                    st_d.rd_n  = 1'b1;
                    st_d.dn    = 1'b1;
                    rd_end     = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_WRITE: begin
                if (st_q.cnt == '0) begin
                    st_d.ph   = PH_HOLD;
                    st_d.wr_n = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_HOLD: begin
                st_d.ph    = PH_DONE;
                st_d.sel_n = 1'b1;
                st_d.sel   = 1'b0;
                st_d.drv   = 1'b0;
                st_d.dn    = 1'b1;
            end
            PH_DONE: st_d.ph = PH_IDLE;
            default: st_d = ST_RST;
        endcase
        if (launch_wr) begin
            st_d.ph    = PH_WRITE;
            st_d.cnt   = CW'(WR_CYC - 1);
            st_d.sel_n = 1'b0;
            st_d.sel   = 1'b1;
            st_d.wr_n  = 1'b0;
            st_d.drv   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_RST;
        else
            st_q <= st_d;
    end

    assign ready     = (st_q.ph == PH_IDLE);
    assign done      = st_q.dn;
    assign rdata     = st_q.rd;
    assign mem_a     = st_q.a;
    assign mem_sel_n = st_q.sel_n;
    assign mem_sel   = st_q.sel;
    assign mem_rd_n  = st_q.rd_n;
    assign mem_wr_n  = st_q.wr_n;
    assign mem_dout  = st_q.wd;
    assign mem_drive = st_q.drv;

endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl #(
    parameter int ADDR_W       = 17,
    parameter int DATA_W       = 8,
    parameter int CLK_NS       = 5,
    parameter int T_ACCESS_NS  = 12,
    parameter int T_RDEN_NS    = 6,
    parameter int T_CYCLE_NS   = 12,
    parameter int T_WPULSE_NS  = 10,
    parameter int T_DSETUP_NS  = 7,
    parameter int T_ASETUP_NS  = 10,
    parameter int T_RELEASE_NS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] mem_a,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic [DATA_W-1:0] mem_dout,
    input  logic [DATA_W-1:0] mem_din,
    output logic              mem_drive
);
    import sram_ctl_pkg::*;

    localparam int RD_CYC = max2(max2(cyc_of(T_ACCESS_NS, CLK_NS), cyc_of(T_RDEN_NS, CLK_NS)),
                                 cyc_of(T_CYCLE_NS, CLK_NS));
    // the hold cycle after the write pulse counts toward the full cycle time
    localparam int WR_CYC = max2(max2(cyc_of(T_WPULSE_NS, CLK_NS), cyc_of(T_DSETUP_NS, CLK_NS)),
                                 max2(cyc_of(T_ASETUP_NS, CLK_NS),
                                      max2(cyc_of(T_CYCLE_NS, CLK_NS) - 1, 1)));
    localparam int TURN_CYC = cyc_of(T_RELEASE_NS, CLK_NS);

    logic gap_clear;
    logic rd_end;

    sram_ctl_gap #(.TURN_CYC(TURN_CYC)) u_gap (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (rd_end),
        .clear_next (gap_clear)
    );

    sram_ctl_seq #(
        .AW     (ADDR_W),
        .DW     (DATA_W),
        .RD_CYC (RD_CYC),
        .WR_CYC (WR_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .gap_clear (gap_clear),
        .rd_end    (rd_end),
        .ready     (ready),
        .done      (done),
        .rdata     (rdata),
        .mem_a     (mem_a),
        .mem_sel_n (mem_sel_n),
        .mem_sel   (mem_sel),
        .mem_rd_n  (mem_rd_n),
        .mem_wr_n  (mem_wr_n),
        .mem_dout  (mem_dout),
        .mem_din   (mem_din),
        .mem_drive (mem_drive)
    );

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
    parameter int ADDR_W   = 17,
    parameter int DATA_W   = 8,
    parameter int WR_CYC   = 2,
    parameter int TURN_CYC = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready,
    input logic              done,
    input logic [ADDR_W-1:0] mem_a,
    input logic              mem_sel_n,
    input logic              mem_sel,
    input logic              mem_rd_n,
    input logic              mem_wr_n,
    input logic [DATA_W-1:0] mem_dout,
    input logic              mem_drive
);
    localparam logic [15:0] SAT = 16'hFFFF;

    logic [15:0] wlow_q, rhigh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wlow_q  <= '0;
            rhigh_q <= SAT;
        end else begin
            wlow_q  <= mem_wr_n ? '0 : ((wlow_q == SAT) ? SAT : wlow_q + 16'd1);
            rhigh_q <= !mem_rd_n ? '0 : ((rhigh_q == SAT) ? SAT : rhigh_q + 16'd1);
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) $rose(rst_n) |-> (ready && !done && mem_sel_n && !mem_sel)); // R1
    AST_READ_QUIET_WE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_n |-> (mem_wr_n && !mem_sel_n && mem_sel)); // R2
    AST_READ_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_n && $past(!mem_rd_n)) |-> $stable(mem_a)); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R3
    AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) done |=> ready); // R3
    AST_WRITE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> (!mem_sel_n && mem_sel && mem_drive)); // R4
    AST_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_wr_n && $past(!mem_wr_n)) |-> ($stable(mem_a) && $stable(mem_dout))); // R4
    AST_WRITE_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_n) |-> (wlow_q >= 16'(WR_CYC))); // R4
    AST_NO_FIGHT: assert property (@(posedge clk) disable iff (!rst_n) !mem_rd_n |-> !mem_drive); // R5
    AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_drive) |-> (rhigh_q >= 16'(TURN_CYC))); // R6
    AST_IDLE_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (mem_sel_n && !mem_sel && !mem_drive && mem_wr_n)); // R8

endmodule

bind sram_async_ctl sram_ctl_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .WR_CYC   (WR_CYC),
    .TURN_CYC (TURN_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ready     (ready),
    .done      (done),
    .mem_a     (mem_a),
    .mem_sel_n (mem_sel_n),
    .mem_sel   (mem_sel),
    .mem_rd_n  (mem_rd_n),
    .mem_wr_n  (mem_wr_n),
    .mem_dout  (mem_dout),
    .mem_drive (mem_drive)
);

// File: tb/tb_sram_async_ctl.sv
module tb_sram_async_ctl;
    localparam int AW = 17;
    localparam int DW = 8;
    // expected at CLK_NS=5: read enable 3 cycles, write pulse 2, release 2
    localparam int EXP_RD = 3;
    localparam int EXP_WR = 2;
    localparam int EXP_LAT = 4;
    localparam int REL_CYC = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          ready, done;
    logic [DW-1:0] rdata;
    logic [AW-1:0] mem_a;
    logic          mem_sel_n, mem_sel, mem_rd_n, mem_wr_n, mem_drive;
    logic [DW-1:0] mem_dout;
    logic [DW-1:0] mem_din = 8'hEE;

    int vectors = 0;
    int fails = 0;
    int rd_low = 0;
    int wr_low = 0;
    int release_left = 0;
    logic [DW-1:0] model [int];

    always #2.5 clk = ~clk;

    sram_async_ctl dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
        .done(done), .rdata(rdata), .mem_a(mem_a), .mem_sel_n(mem_sel_n),
        .mem_sel(mem_sel), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .mem_dout(mem_dout), .mem_din(mem_din), .mem_drive(mem_drive)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // memory model and bus monitor, evaluated mid-cycle
    always @(negedge clk) begin
        logic selected, mem_drives;
        selected   = !mem_sel_n && mem_sel;
        mem_drives = selected && !mem_rd_n && mem_wr_n;
        if (mem_drive && (mem_drives || release_left > 0)) begin
            vectors++; fails++;
            $display("FAIL R6: bus driven while memory drives, actual drive=%0d expected 0", mem_drive);
        end
        if (mem_drive && !mem_rd_n) begin
            vectors++; fails++;
            $display("FAIL R5: driver on with read enable low, actual 1 expected 0");
        end
        if (selected && !mem_wr_n) begin
            if (!mem_drive) begin
                vectors++; fails++;
                $display("FAIL R4: write pulse without driver, actual 0 expected 1");
            end
            model[int'(mem_a)] = mem_dout;
            wr_low++;
        end
        if (mem_drives) rd_low++;
        release_left = mem_drives ? REL_CYC : ((release_left > 0) ? release_left - 1 : 0);
        if (mem_drives)
            mem_din <= model.exists(int'(mem_a)) ? model[int'(mem_a)] : 8'h00;
        else
            mem_din <= 8'hEE;
    end

    task automatic issue(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         output int lat);
        while (!ready) @(negedge clk);
        rd_low = 0; wr_low = 0;
        req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        @(negedge clk);
        req = 1'b0;
        lat = 1;
        while (!done && lat < 50) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic after_done(input string tag);
        @(negedge clk);
        check(ready == 1'b1, {tag, " R3 ready after done"}, ready, 1);
        check(done == 1'b0, {tag, " R3 done single cycle"}, done, 0);
        check(mem_sel_n && !mem_sel && !mem_drive, {tag, " R8 parked when ready"},
              {mem_sel_n, mem_sel, mem_drive}, 3'b100);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int lat;
        issue(1'b1, a, d, lat);
        check(lat == EXP_LAT, "R3 write latency", lat, EXP_LAT);
        check(wr_low == EXP_WR, "R4 write pulse cycles", wr_low, EXP_WR);
        check(model.exists(int'(a)) && model[int'(a)] == d, "R4 stored byte",
              model.exists(int'(a)) ? model[int'(a)] : -1, d);
        after_done("wr");
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
        int lat;
        issue(1'b0, a, 8'h00, lat);
        check(lat == EXP_LAT, "R3 read latency", lat, EXP_LAT);
        check(rd_low == EXP_RD, "R2 read enable cycles", rd_low, EXP_RD);
        check(rdata == exp, "R3 read data", rdata, exp);
        after_done("rd");
    endtask

    task automatic test_reset();
        check(ready == 1'b1, "R1 ready", ready, 1);
        check(done == 1'b0, "R1 done", done, 0);
        check(mem_sel_n == 1'b1 && mem_sel == 1'b0, "R1 deselected", {mem_sel_n, mem_sel}, 2'b10);
        check(mem_rd_n && mem_wr_n, "R1 strobes high", {mem_rd_n, mem_wr_n}, 2'b11);
        check(mem_drive == 1'b0, "R1 driver off", mem_drive, 0);
    endtask

    task automatic test_patterns();
        do_write(17'h00000, 8'hA5);
        do_write(17'h1FFFF, 8'h3C);
        do_write(17'h0AAAA, 8'hFF);
        do_write(17'h15555, 8'h00);
        do_read(17'h00000, 8'hA5);
        do_read(17'h1FFFF, 8'h3C);
        do_read(17'h0AAAA, 8'hFF);
        do_read(17'h15555, 8'h00);
    endtask

    task automatic test_turnaround();
        // read followed at once by a write, then write followed by read (R6)
        do_read(17'h1FFFF, 8'h3C);
        do_write(17'h1FFFF, 8'h96);
        do_read(17'h1FFFF, 8'h96);
        do_write(17'h00001, 8'h5A);
        do_read(17'h00001, 8'h5A);
    endtask

    task automatic test_busy_ignored();
        int dones;
        while (!ready) @(negedge clk);
        req = 1'b1; req_we = 1'b1; req_addr = 17'h00002; req_wdata = 8'h11;
        @(negedge clk);
        // busy now: a second request aimed at 0x0AAAA must be dropped (R7)
        req_addr = 17'h0AAAA; req_wdata = 8'h77;
        dones = 0;
        for (int i = 0; i < 3; i++) begin
            if (done) dones++;
            @(negedge clk);
        end
        req = 1'b0;
        for (int i = 0; i < 6; i++) begin
            if (done) dones++;
            @(negedge clk);
        end
        check(dones == 1, "R7 single done for busy request", dones, 1);
        do_read(17'h0AAAA, 8'hFF);
        do_read(17'h00002, 8'h11);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_patterns();
        test_turnaround();
        test_busy_ignored();
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        vectors++; fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule